// File: doc/BRIEF.md
# Subgroup-folded lane rotation controller

This block sits between a reduced bank of P functional units and a message memory whose words carry one 5-bit message per unit. The full code structure is built around groups of M = 360 nodes, with one cyclic shift and one base row stored for each group. The hardware has only P = M/L units, where L is an integer divisor of 360. Each group is therefore handled as L consecutive subgroups of P nodes. For every subgroup the block derives the rotation amount and the memory row from the single stored entry. It then rotates the word by that amount across P lanes, so a narrow rotator stands in for a 360-lane one and the table stays the same size.

Each accepted word access advances a subgroup counter. The access that uses the last subgroup raises a request for the next table entry. The direction of the rotation depends on the decoding phase. In the bit-node phase the data is rotated right and the row comes from a sequential counter. In the check-node phase the data is rotated left and the row comes from the table entry. The rotated word, its row and its subgroup index appear one clock after the access, qualified by a valid flag.

Top module: `fold_rotor_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid, out_data, out_addr and out_sub are all zero. The subgroup counter and the sequential row counter both start at zero.
- R2: The subgroup index g advances by one on each access (in_valid high) and wraps from L-1 to 0. Cycles with in_valid low leave it unchanged. out_sub reports the g that the access used.
- R3: rom_next is high in exactly those cycles where in_valid is high and g equals L-1. The table entry on rom_shift0 and rom_addr0 must be held until that cycle has passed.
- R4: The lane rotation amount for an access is s = ((rom_shift0 + g) div L) mod P. When rom_shift0 + g reaches M, the quotient equals P and s wraps to 0.
- R5: With in_mode = 0 (bit-node phase), output lane j takes input lane (j + s) mod P. Lane j occupies bits [5j+4:5j].
- R6: With in_mode = 1 (check-node phase), output lane j takes input lane (j - s) mod P.
- R7: In bit-node accesses, out_addr is a sequential counter. It starts at zero, advances by one after each bit-node access and wraps at 2^AW. Check-node accesses do not move it.
- R8: In check-node accesses, out_addr = (rom_addr0 × L + g) mod 2^AW.
- R9: out_valid is high exactly one cycle after each access and low otherwise. out_data, out_addr and out_sub belong to that access.
- R10: After a cycle with in_valid low, out_data, out_addr and out_sub keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One word access this cycle |
| in_mode | input | 1 | 0 = bit-node phase (rotate right), 1 = check-node phase (rotate left) |
| in_data | input | P×5 | Word of P messages, lane j at bits 5j+4:5j |
| rom_shift0 | input | 9 | Stored shift of the current group (0..359) |
| rom_addr0 | input | AW | Stored base row of the current group |
| rom_next | output | 1 | Current entry is used up after this access |
| out_valid | output | 1 | Output word is valid |
| out_data | output | P×5 | Rotated word |
| out_addr | output | AW | Memory row for the rotated word |
| out_sub | output | max(1,log2 L) | Subgroup index of the access |

## Verification
The bench builds the block with L = 8, which gives P = 45 lanes, and with AW = 6. A stored shift of 359 combined with subgroup 7 gives a quotient of exactly P, so the mod-P wrap of the rotation amount is reached. The narrow row width lets both the sequential row counter and the scaled check-node row wrap within a few hundred cycles. Random accesses with random gaps and random phase changes cover both rotation directions. They also cover a phase change in the middle of a group and the holding of outputs over idle cycles, against a model that recomputes every lane on every clock.

// File: rtl/fold_pkg.sv
// Package: shared constants and types for the folded lane rotation controller.
// Assumes: the group size is fixed at 360 nodes for every code.
package fold_pkg;
    localparam int M_NODES = 360;

    typedef enum logic {
        PHASE_BIT   = 1'b0,
        PHASE_CHECK = 1'b1
    } phase_e;
endpackage

// File: rtl/fold_subgroup_seq.sv
// Subgroup sequencer: counts accesses within a group and keeps the
// sequential row counter used in the bit-node phase.
// Assumes: one access per cycle at most; L >= 1.
module fold_subgroup_seq #(
    parameter int L  = 8,
    parameter int GW = 3,
    parameter int AW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  fold_pkg::phase_e     acc_phase,
    output logic [GW-1:0]        sub_idx,
    output logic [AW-1:0]        seq_row,
    output logic                 last_sub
);
    localparam logic [GW-1:0] LAST = GW'(L - 1);

    // Flags the final subgroup of the current group.
    always_comb last_sub = (sub_idx == LAST);

    // Advances the subgroup index on each access and wraps after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_idx <= '0;
        else if (acc_valid)
            sub_idx <= last_sub ? '0 : sub_idx + 1'b1;
    end

    // Steps the sequential row on bit-node accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_row <= '0;
        else if (acc_valid && acc_phase == fold_pkg::PHASE_BIT)
            seq_row <= seq_row + 1'b1;
    end
endmodule

// File: rtl/fold_shift_calc.sv
// Shift and row arithmetic: derives the lane rotation of a subgroup from the
// stored group shift, and the check-node row from the stored base row.
// Assumes: shift0 < M; the result of the division never exceeds P.
module fold_shift_calc #(
    parameter int M   = 360,
    parameter int L   = 8,
    parameter int P   = 45,
    parameter int SHW = 9,
    parameter int SW  = 6,
    parameter int GW  = 3,
    parameter int AW  = 12
) (
    input  logic [SHW-1:0] shift0,
    input  logic [AW-1:0]  row0,
    input  logic [GW-1:0]  sub_idx,
    output logic [SW-1:0]  lane_shift,
    output logic [AW-1:0]  cn_row
);
    localparam int QW = SHW + 1;

    logic [QW-1:0] sum_w;
    logic [QW-1:0] quo_w;
    logic [QW-1:0] wrap_w;

    // Forms (shift0 + g) div L, then folds the value P back to zero.
    always_comb begin
        sum_w      = {1'b0, shift0} + QW'(sub_idx);
        quo_w      = sum_w / QW'(L);
        wrap_w     = (quo_w >= QW'(P)) ? quo_w - QW'(P) : quo_w;
        lane_shift = SW'(wrap_w);
    end

    // Expands the base row into L consecutive rows, one per subgroup.
    always_comb cn_row = row0 * AW'(L) + AW'(sub_idx);
endmodule

// File: rtl/fold_lane_rotator.sv
// Lane rotator: cyclic rotation of P lanes of W bits in log2(P) mux stages,
// with one output register loaded on each access.
// Assumes: P >= 2 and shift < P. A left rotation is done as a right rotation by P - shift.
module fold_lane_rotator #(
    parameter int P  = 45,
    parameter int W  = 5,
    parameter int SW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  fold_pkg::phase_e     phase,
    input  logic [SW-1:0]        shift,
    input  logic [P*W-1:0]       din,
    output logic [P*W-1:0]       dout
);
    localparam int NST = SW;

    logic [SW-1:0]  amt;
    logic [W-1:0]   stg [NST+1][P];
    logic [P*W-1:0] rot_flat;

    // Converts the requested direction into a right rotation amount.
    always_comb begin
        if (phase == fold_pkg::PHASE_CHECK)
            amt = (shift == '0) ? '0 : SW'(P) - shift;
        else
            amt = shift;
    end

    for (genvar j = 0; j < P; j++) begin : g_in
        assign stg[0][j] = din[j*W +: W];
    end

    for (genvar k = 0; k < NST; k++) begin : g_stage
        localparam int STEP = (1 << k) % P;
        for (genvar j = 0; j < P; j++) begin : g_lane
            assign stg[k+1][j] = amt[k] ? stg[k][(j + STEP) % P] : stg[k][j];
        end
    end

    for (genvar j = 0; j < P; j++) begin : g_out
        assign rot_flat[j*W +: W] = stg[NST][j];
    end

    // Captures the rotated word on each access and holds it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= rot_flat;
    end
endmodule

// File: rtl/fold_rotor_ctrl.sv
// Top: folded lane rotation controller. P = 360/L lanes stand in for a
// 360-lane rotator by working through each stored group in L subgroups.
// Assumes: the table entry is held until rom_next has been seen; L divides 360
// and P >= 2.
module fold_rotor_ctrl #(
    parameter  int L   = 8,
    parameter  int W   = 5,
    parameter  int AW  = 12,
    localparam int M   = fold_pkg::M_NODES,
    localparam int P   = M / L,
    localparam int SHW = $clog2(M),
    localparam int SW  = $clog2(P),
    localparam int GW  = (L > 1) ? $clog2(L) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_mode,
    input  logic [P*W-1:0] in_data,
    input  logic [SHW-1:0] rom_shift0,
    input  logic [AW-1:0]  rom_addr0,
    output logic           rom_next,
    output logic           out_valid,
    output logic [P*W-1:0] out_data,
    output logic [AW-1:0]  out_addr,
    output logic [GW-1:0]  out_sub
);
    fold_pkg::phase_e phase;
    logic [GW-1:0]    sub_idx;
    logic [AW-1:0]    seq_row;
    logic [AW-1:0]    cn_row;
    logic [SW-1:0]    lane_shift;
    logic             last_sub;

    // Maps the mode pin onto the phase type.
    always_comb phase = in_mode ? fold_pkg::PHASE_CHECK : fold_pkg::PHASE_BIT;

    fold_subgroup_seq #(.L(L), .GW(GW), .AW(AW)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(in_valid),
        .acc_phase(phase),
        .sub_idx  (sub_idx),
        .seq_row  (seq_row),
        .last_sub (last_sub)
    );

    fold_shift_calc #(.M(M), .L(L), .P(P), .SHW(SHW), .SW(SW), .GW(GW), .AW(AW)) i_calc (
        .shift0    (rom_shift0),
        .row0      (rom_addr0),
        .sub_idx   (sub_idx),
        .lane_shift(lane_shift),
        .cn_row    (cn_row)
    );

    fold_lane_rotator #(.P(P), .W(W), .SW(SW)) i_rot (
        .clk  (clk),
        .rst_n(rst_n),
        .load (in_valid),
        .phase(phase),
        .shift(lane_shift),
        .din  (in_data),
        .dout (out_data)
    );

    // Requests the next table entry on the access that closes a group.
    always_comb rom_next = in_valid && last_sub;

    // Registers the valid flag alongside the rotated data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Registers the row and subgroup index of each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_sub  <= '0;
        end else if (in_valid) begin
            out_addr <= (phase == fold_pkg::PHASE_CHECK) ? cn_row : seq_row;
            out_sub  <= sub_idx;
        end
    end
endmodule

// File: rtl/fold_rotor_ctrl_chk.sv
// Checker: temporal properties of the folded lane rotation controller's ports.
// Assumes: bound to every instance of fold_rotor_ctrl.
module fold_rotor_ctrl_chk #(
    parameter  int L   = 8,
    parameter  int W   = 5,
    parameter  int AW  = 12,
    localparam int M   = fold_pkg::M_NODES,
    localparam int P   = M / L,
    localparam int SHW = $clog2(M),
    localparam int GW  = (L > 1) ? $clog2(L) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_mode,
    input logic [P*W-1:0] in_data,
    input logic [SHW-1:0] rom_shift0,
    input logic [AW-1:0]  rom_addr0,
    input logic           rom_next,
    input logic           out_valid,
    input logic [P*W-1:0] out_data,
    input logic [AW-1:0]  out_addr,
    input logic [GW-1:0]  out_sub
);
    a_r9_valid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_next_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        rom_next |-> in_valid);

    a_r3_next_on_last_sub: assert property (@(posedge clk) disable iff (!rst_n)
        rom_next |=> (out_sub == GW'(L - 1)));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_addr) && $stable(out_sub)));

    a_r2_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sub) < L));
endmodule

bind fold_rotor_ctrl fold_rotor_ctrl_chk #(.L(L), .W(W), .AW(AW)) i_chk (.*);

// File: tb/test_fold_rotor_ctrl.sv
// Bench: random accesses checked against a behavioural model on every clock.
module test_fold_rotor_ctrl;
    localparam int L   = 8;
    localparam int W   = 5;
    localparam int AW  = 6;
    localparam int M   = 360;
    localparam int P   = M / L;
    localparam int GW  = 3;
    localparam int NCYC = 700;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic           in_mode;
    logic [P*W-1:0] in_data;
    logic [8:0]     rom_shift0;
    logic [AW-1:0]  rom_addr0;
    logic           rom_next;
    logic           out_valid;
    logic [P*W-1:0] out_data;
    logic [AW-1:0]  out_addr;
    logic [GW-1:0]  out_sub;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    fold_rotor_ctrl #(.L(L), .W(W), .AW(AW)) i_fold_rotor_ctrl (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [P*W-1:0] exp_data;
        logic [AW-1:0]  exp_addr;
        logic [GW-1:0]  exp_sub;
        logic           exp_valid;
        string          dtag;
        string          atag;
        int             g_ref;
        int             bn_ref;
        int             entry_no;
        bit             need_entry;

        exp_data = '0; exp_addr = '0; exp_sub = '0; exp_valid = 1'b0;
        dtag = "R1"; atag = "R1";
        g_ref = 0; bn_ref = 0; entry_no = 0; need_entry = 1;

        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = '0;
        rom_shift0 = '0; rom_addr0 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 out_valid", 256'(out_valid), 256'(0));
        chk("R1 out_data", 256'(out_data), 256'(0));
        chk("R1 out_addr", 256'(out_addr), 256'(0));
        chk("R1 out_sub", 256'(out_sub), 256'(0));
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            // Registered results of the previous cycle's access (R9).
            chk("R9 out_valid", 256'(out_valid), 256'(exp_valid));
            chk(dtag, 256'(out_data), 256'(exp_data));
            chk(atag, 256'(out_addr), 256'(exp_addr));
            chk("R2 out_sub", 256'(out_sub), 256'(exp_sub));

            // New table entry after the previous group closed.
            if (need_entry) begin
                if (entry_no % 4 == 0)      rom_shift0 = 9'd359;
                else if (entry_no % 4 == 1) rom_shift0 = 9'd0;
                else                        rom_shift0 = 9'($urandom % M);
                rom_addr0  = AW'($urandom);
                entry_no++;
                need_entry = 0;
            end
            in_valid = (cyc >= 200 && cyc < 215) ? 1'b0 : (($urandom % 10) < 7);
            in_mode  = ($urandom % 2) == 1;
            for (int j = 0; j < P; j++) in_data[j*W +: W] = W'($urandom);

            #1;
            // R3: entry request only on the last subgroup's access
            chk("R3 rom_next", 256'(rom_next), 256'(in_valid && (g_ref == L - 1)));

            exp_valid = in_valid;
            if (in_valid) begin
                // R4: s = ((shift0 + g) div L) mod P
                int s;
                s = ((int'(rom_shift0) + g_ref) / L) % P;
                for (int j = 0; j < P; j++) begin
                    if (in_mode) exp_data[j*W +: W] = in_data[((j - s + P) % P)*W +: W];
                    else         exp_data[j*W +: W] = in_data[((j + s) % P)*W +: W];
                end
                dtag = in_mode ? "R6 R4 left rotation" : "R5 R4 right rotation";
                if (in_mode) begin
                    exp_addr = AW'((int'(rom_addr0) * L + g_ref) % (1 << AW));
                    atag = "R8 check-node row";
                end else begin
                    exp_addr = AW'(bn_ref);
                    atag = "R7 sequential row";
                    bn_ref = (bn_ref + 1) % (1 << AW);
                end
                exp_sub = GW'(g_ref);
                if (g_ref == L - 1) need_entry = 1;
                g_ref = (g_ref + 1) % L;
            end else begin
                dtag = "R10 data held";
                atag = "R10 row held";
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule